// File: doc/BRIEF.md
# MDIO management frame master

This block lets a host read and write 16-bit PHY management registers over a two-wire serial management bus. The host presents a request (read or write select, 5-bit PHY address, 5-bit register number and, for writes, a 16-bit value) together with a one-cycle start strobe. The block then produces one complete management frame on the clock, data and data-enable outputs, and ends it with a one-cycle done pulse. For a read, the 16-bit value returned by the PHY is available on the read data output from that pulse on.

Every frame carries a full 32-bit all-ones preamble. The clock half-period is a parameter that counts system clock cycles. The data output and its enable change only while the management clock is low. Incoming data is synchronised through two flops and sampled at the end of each clock-high phase. The output enable is driven explicitly for every bit time, so that an external pad can release the line during the turnaround and the read data field.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc_o, mdio_o, mdio_oe_o, busy_o and done_o are 0 and rdata_o is 0.
- R2: Bit times 0 to 31 of a frame carry mdio_o=1 with mdio_oe_o=1.
- R3: Bit times 32 and 33 carry 0 then 1. Bit times 34 and 35 carry 1,0 for a read (rd_i=1) and 0,1 for a write. The enable is high for all four.
- R4: Bit times 36 to 40 carry phy_i and bit times 41 to 45 carry reg_i, each most significant bit first, with the enable high.
- R5: In a write, bit times 46 and 47 have mdio_oe_o=0. Bit times 48 to 63 then carry wdata_i most significant bit first, with mdio_oe_o=1.
- R6: In a read, mdio_oe_o is 0 from bit time 46 to bit time 63. The mdio_i values seen in bit times 48 to 63 form rdata_o, most significant bit first, and rdata_o holds that value from the done pulse on.
- R7: Each clock-low and clock-high phase lasts HALF_CYC system clocks. mdio_o and mdio_oe_o do not change while mdc_o is high. done_o rises 130*HALF_CYC cycles after the accepting edge.
- R8: Bit time 64 is one extra clock period with mdio_oe_o=0, so a frame has 65 rising mdc_o edges. After it, mdc_o, mdio_o and mdio_oe_o are all 0.
- R9: busy_o rises on the edge that accepts start_i and stays high until done_o. done_o lasts exactly one cycle, and busy_o is 0 in that cycle.
- R10: A start_i pulse that arrives while busy_o is high has no effect on the frame in progress and starts no further frame.
- R11: A start_i that arrives in the cycle in which done_o is high is accepted and begins a new frame.
- R12: rdata_o changes only when a read frame completes; a write frame leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register number |
| wdata_i | input | 16 | Write value |
| rdata_o | output | 16 | Value captured by the last read |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in (asynchronous) |

## Verification
The completion of one frame and the acceptance of the next request can fall in the same cycle. The bench waits for done_o and raises start_i during that same cycle with a new set of fields. It then expects busy_o to be high one cycle later and the following frame to decode to the new fields. A second collision is a request that arrives in the middle of a frame. The bench judges it by checking that the running frame still decodes to the original request and that busy_o stays low once that frame has ended.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN = 32;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;

  localparam int IDX_ST  = PRE_LEN;
  localparam int IDX_OP  = IDX_ST + 2;
  localparam int IDX_PHY = IDX_OP + 2;
  localparam int IDX_REG = IDX_PHY + ADDR_W;
  localparam int IDX_TA  = IDX_REG + ADDR_W;
  localparam int IDX_DAT = IDX_TA + 2;
  localparam int IDX_END = IDX_DAT + DATA_W;
  localparam int IDX_W   = $clog2(IDX_END + 1);

  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t B_ST  = idx_t'(IDX_ST);
  localparam idx_t B_OP  = idx_t'(IDX_OP);
  localparam idx_t B_PHY = idx_t'(IDX_PHY);
  localparam idx_t B_REG = idx_t'(IDX_REG);
  localparam idx_t B_TA  = idx_t'(IDX_TA);
  localparam idx_t B_DAT = idx_t'(IDX_DAT);
  localparam idx_t B_END = idx_t'(IDX_END);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] wdata;
  } req_t;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= {q_o[DATA_W-2:0], bit_i};
  end
endmodule

// File: rtl/mdio_bitsel.sv
module mdio_bitsel
  import mdio_pkg::*;
(
  input  idx_t idx_i,
  input  req_t req_i,
  output logic d_o,
  output logic oe_o
);
  idx_t              off;
  logic [ADDR_W-1:0] a_sh;
  logic [DATA_W-1:0] w_sh;

  always_comb begin
    d_o  = 1'b0;
    oe_o = 1'b0;
    off  = '0;
    a_sh = '0;
    w_sh = '0;
    if (idx_i < B_ST) begin
      d_o  = 1'b1;
      oe_o = 1'b1;
    end else if (idx_i < B_OP) begin
      d_o  = (idx_i != B_ST);
      oe_o = 1'b1;
    end else if (idx_i < B_PHY) begin
      d_o  = req_i.rd ? (idx_i == B_OP) : (idx_i != B_OP);
      oe_o = 1'b1;
    end else if (idx_i < B_REG) begin
      off  = idx_i - B_PHY;
      a_sh = req_i.phy << off;
      d_o  = a_sh[ADDR_W-1];
      oe_o = 1'b1;
    end else if (idx_i < B_TA) begin
      off  = idx_i - B_REG;
      a_sh = req_i.regn << off;
      d_o  = a_sh[ADDR_W-1];
      oe_o = 1'b1;
    end else if (idx_i < B_DAT) begin
      d_o  = 1'b0;
      oe_o = 1'b0;
    end else if (idx_i < B_END) begin
      if (!req_i.rd) begin
        off  = idx_i - B_DAT;
        w_sh = req_i.wdata << off;
        d_o  = w_sh[DATA_W-1];
        oe_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  state_e            state_q;
  req_t              req_q, req_in, sel_req;
  idx_t              idx_q, sel_idx;
  logic              phase_q;
  logic              mdc_q, d_q, oe_q, done_q;
  logic [DATA_W-1:0] rdata_q, cap_q;
  logic              tick, accept, last, nd, noe, mdio_s, cap_en;

  assign req_in  = '{rd: rd_i, phy: phy_i, regn: reg_i, wdata: wdata_i};
  assign accept  = (state_q == ST_IDLE) && start_i;
  assign last    = (idx_q == B_END);
  assign sel_req = accept ? req_in : req_q;
  assign sel_idx = accept ? '0 : idx_q + 1'b1;
  // sample at the end of a clock-high phase inside the read data field
  assign cap_en  = (state_q == ST_RUN) && tick && phase_q && req_q.rd &&
                   (idx_q >= B_DAT) && (idx_q < B_END);

  mdio_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == ST_RUN),
    .tick_o(tick)
  );

  mdio_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mdio_i),
    .q_o   (mdio_s)
  );

  mdio_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(cap_en),
    .bit_i  (mdio_s),
    .q_o    (cap_q)
  );

  mdio_bitsel u_bitsel (
    .idx_i(sel_idx),
    .req_i(sel_req),
    .d_o  (nd),
    .oe_o (noe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      idx_q   <= '0;
      phase_q <= 1'b0;
      mdc_q   <= 1'b0;
      d_q     <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= ST_RUN;
        req_q   <= req_in;
        idx_q   <= '0;
        phase_q <= 1'b0;
        mdc_q   <= 1'b0;
        d_q     <= nd;
        oe_q    <= noe;
      end else if (state_q == ST_RUN && tick) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
          mdc_q   <= 1'b1;
        end else if (last) begin
          state_q <= ST_IDLE;
          phase_q <= 1'b0;
          mdc_q   <= 1'b0;
          d_q     <= 1'b0;
          oe_q    <= 1'b0;
          done_q  <= 1'b1;
          if (req_q.rd) rdata_q <= cap_q;
        end else begin
          idx_q   <= sel_idx;
          phase_q <= 1'b0;
          mdc_q   <= 1'b0;
          d_q     <= nd;
          oe_q    <= noe;
        end
      end
    end
  end

  assign busy_o    = (state_q == ST_RUN);
  assign done_o    = done_q;
  assign mdc_o     = mdc_q;
  assign mdio_o    = d_q;
  assign mdio_oe_o = oe_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_cnt <= '0;
    else if (mdc_o) hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  a_r7_half_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> hi_cnt == 32'(HALF_CYC));

  a_r7_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r10_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !$rose(mdc_o) && !mdc_o) |=> (busy_o || done_o));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int FRAME_CYC = 130 * HALF + 1;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, rd_i = 1'b0;
  logic [4:0]  phy_i = '0, reg_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int errors = 0, checks = 0, cycles = 0, edge_cnt = 0;
  logic [15:0] phy_val = '0;
  logic cap_d [0:79];
  logic cap_oe[0:79];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mdio_master #(.HALF_CYC(HALF)) u0 (.*);

  always @(posedge mdc_o) begin
    if (edge_cnt < 80) begin
      cap_d[edge_cnt]  = mdio_o;
      cap_oe[edge_cnt] = mdio_oe_o;
    end
    edge_cnt++;
  end

  // PHY model: present read data for the coming bit time while mdc is low
  always @(negedge mdc_o) begin
    if (edge_cnt >= 48 && edge_cnt <= 63) mdio_i = phy_val[63-edge_cnt];
    else                                   mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pv);
    phy_val  = pv;
    edge_cnt = 0;
    rd_i = rd; phy_i = phy; reg_i = rg; wdata_i = wd;
    start_i = 1'b1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 1) begin
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
      end
    end while (!done_o && cyc < 4000);
  endtask

  task automatic check_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd);
    bit ok;
    logic [4:0] pa, ra;
    logic [15:0] dv;
    chk(edge_cnt == 65, "R8 rising edges", edge_cnt, 65);
    ok = 1;
    for (int i = 0; i < 32; i++) ok &= (cap_d[i] === 1'b1) && (cap_oe[i] === 1'b1);
    chk(ok, "R2 preamble", ok, 1);
    ok = (cap_d[32] === 1'b0) && (cap_d[33] === 1'b1) &&
         (cap_d[34] === rd) && (cap_d[35] === !rd);
    for (int i = 32; i < 36; i++) ok &= (cap_oe[i] === 1'b1);
    chk(ok, "R3 start/opcode", {cap_d[32], cap_d[33], cap_d[34], cap_d[35]},
        {2'b01, rd, !rd});
    ok = 1;
    for (int i = 0; i < 5; i++) begin
      pa[4-i] = cap_d[36+i];
      ra[4-i] = cap_d[41+i];
      ok &= (cap_oe[36+i] === 1'b1) && (cap_oe[41+i] === 1'b1);
    end
    chk(ok && pa == phy, "R4 phy address", pa, phy);
    chk(ok && ra == rg, "R4 register number", ra, rg);
    ok = (cap_oe[46] === 1'b0) && (cap_oe[47] === 1'b0);
    for (int i = 0; i < 16; i++) begin
      dv[15-i] = cap_d[48+i];
      ok &= (cap_oe[48+i] === !rd);
    end
    if (rd) chk(ok, "R6 line released", ok, 1);
    else begin
      chk(ok, "R5 turnaround/data enable", ok, 1);
      chk(dv == wd, "R5 write data", dv, wd);
    end
    chk(cap_oe[64] === 1'b0, "R8 final bit released", cap_oe[64], 0);
    chk(!mdc_o && !mdio_o && !mdio_oe_o && !busy_o && done_o,
        "R8 idle after frame", {mdc_o, mdio_o, mdio_oe_o, busy_o, done_o}, 5'b00001);
  endtask

  task automatic t_reset;
    chk({mdc_o, mdio_o, mdio_oe_o, busy_o, done_o} == 5'b0 && rdata_o == 16'h0,
        "R1 reset state", {rdata_o, mdc_o, mdio_o, mdio_oe_o, busy_o, done_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    int cyc;
    logic [15:0] rd_before;
    rd_before = rdata_o;
    @(negedge clk_i);
    start_req(1'b0, phy, rg, wd, 16'h0);
    wait_done(cyc);
    chk(cyc == FRAME_CYC, "R7 frame length", cyc, FRAME_CYC);
    check_frame(1'b0, phy, rg, wd);
    chk(rdata_o == rd_before, "R12 write keeps rdata", rdata_o, rd_before);
    @(negedge clk_i);
    chk(!done_o, "R9 done single cycle", done_o, 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pv);
    int cyc;
    @(negedge clk_i);
    start_req(1'b1, phy, rg, 16'hFFFF, pv);
    wait_done(cyc);
    chk(cyc == FRAME_CYC, "R7 frame length", cyc, FRAME_CYC);
    check_frame(1'b1, phy, rg, 16'h0);
    chk(rdata_o == pv, "R6 read data", rdata_o, pv);
    @(negedge clk_i);
    chk(!done_o, "R9 done single cycle", done_o, 0);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    @(negedge clk_i);
    start_req(1'b0, 5'h0C, 5'h03, 16'h1234, 16'h0);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (150) @(negedge clk_i);
    rd_i = 1'b1; phy_i = 5'h1F; reg_i = 5'h1E; wdata_i = 16'hFFFF;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 4000) begin @(negedge clk_i); cyc++; end
    check_frame(1'b0, 5'h0C, 5'h03, 16'h1234);
    repeat (30) @(negedge clk_i);
    chk(!busy_o && edge_cnt == 65, "R10 start while busy ignored", {busy_o, 7'(edge_cnt)}, 65);
  endtask

  task automatic t_back2back;
    int cyc;
    @(negedge clk_i);
    start_req(1'b0, 5'h01, 5'h10, 16'h8001, 16'h0);
    wait_done(cyc);
    check_frame(1'b0, 5'h01, 5'h10, 16'h8001);
    // still in the done cycle: request the next frame now
    start_req(1'b1, 5'h15, 5'h0A, 16'h0, 16'h6C39);
    wait_done(cyc);
    chk(cyc == FRAME_CYC, "R11 start in done cycle accepted", cyc, FRAME_CYC);
    check_frame(1'b1, 5'h15, 5'h0A, 16'h0);
    chk(rdata_o == 16'h6C39, "R11 second frame read data", rdata_o, 16'h6C39);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_write(5'h05, 5'h11, 16'hA5C3);
    t_write(5'h1F, 5'h00, 16'h0000);
    t_read(5'h00, 5'h1F, 16'hBEEF);
    t_write(5'h0A, 5'h15, 16'hFFFF);
    t_read(5'h12, 5'h09, 16'h0001);
    t_read(5'h03, 5'h02, 16'h8000);
    t_busy_ignore();
    t_back2back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule